// File: doc/BRIEF.md
# Retimer Configuration Sequencer

This block brings up a video-link retimer over I2C on its own. It starts once after reset is released, and again on each `start_i` pulse received while idle. It captures the line rate (in Mbps) and then finds out which of two device variants is fitted by reading one byte from each of two bus addresses in turn. It then picks a rate band and works through a fixed register script for that variant and band. Along the way it inserts millisecond pauses between analog power-up steps. It signals the outcome with a one-cycle `done_o` or `err_o` pulse.

The block talks to a byte-level I2C master through a command stream and a response strobe. The command stream uses valid/ready. Once `cmd_valid_o` is raised, it stays high and every command field stays unchanged until the cycle in which `cmd_ready_i` is sampled high. That cycle is the handshake. The master may hold `cmd_ready_i` low for as long as it needs, and the sequencer simply waits. After each handshake the sequencer issues nothing else until the master returns a single-cycle `rsp_valid_i`. That strobe carries a nack flag and the number of bytes transferred. The response side has no back-pressure.

Top module: `retimer_cfg_seq`

## Requirements
- R1: While reset is asserted, `cmd_valid_o`, `busy_o`, `done_o` and `err_o` are low. After reset is released, a full configuration run starts without any `start_i` pulse.
- R2: The first command is a one-byte read at address 0x2C. It counts as found only if the response has no nack and a byte count of exactly 1. Otherwise a one-byte read at 0x5E follows, judged the same way. If neither is found, `err_o` pulses and no write is issued. `variant_b_o` is 1 when the 0x5E device is in use.
- R3: Every register write is a single command with `cmd_rd_o`=0, `cmd_len_o`=2, `cmd_byte0_o` = register index, `cmd_byte1_o` = data and `cmd_stop_o`=1. It succeeds only on a response with no nack and a count of 2.
- R4: For the 0x2C device the band is chosen as follows: above 3400 Mbps is band 2, above 1200 is band 1, and anything else is band 0.
- R5: The 0x2C script is these writes, in this order: FF=01, 04=(80,40,80), 05=(02,01,02), 08=(02,04,04), 0E=10, 01=81, 00=02, 00=03, 10=0F, 14=10, 16=10, 17=00, 12=28, 13=0F, 13=00, 11=(C0,70,30), 30=0F, 32=00, 31=(C0,40,00), 34=00, 3C=04, 3D=06, 4D=(38,28,18), 4C=03, FF=00, 09=01, E0=01, 09=00. Values in brackets are for bands 0, 1 and 2.
- R6: In the 0x2C script, at least WAIT cycles separate the handshake of 01=81 from that of 00=02. The same gap separates 00=02 from 00=03.
- R7: For the 0x5E device, band 2 is above 3400 Mbps, band 1 is above 2000, and band 0 is anything else. The script is 09=06, 0B=(80,88,9A), 0C=(48,48,49), 0D=00, then 0A=(35,35,36) last.
- R8: The line rate is sampled when the run starts. Later changes on `rate_mbps_i` do not alter the run in progress.
- R9: If a write response is nacked or short, the run stops. `err_o` pulses, no further command is issued, and the block returns to idle.
- R10: `done_o` and `err_o` are one-cycle pulses and are never high together. `busy_o` is high from the run start until the cycle of the pulse. No command is offered while idle.
- R11: While `cmd_valid_o` is high and `cmd_ready_i` is low, the next cycle keeps `cmd_valid_o` high with unchanged address, direction and bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a run (taken only when idle) |
| rate_mbps_i | input | RATE_W | Line rate in Mbps |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Master accepts the command |
| cmd_addr_o | output | 7 | 7-bit bus address |
| cmd_rd_o | output | 1 | 1 = read, 0 = write |
| cmd_len_o | output | 2 | Number of bytes in the transaction |
| cmd_byte0_o | output | 8 | First write byte (register index) |
| cmd_byte1_o | output | 8 | Second write byte (data) |
| cmd_stop_o | output | 1 | End with stop (0 would mean repeated start) |
| rsp_valid_i | input | 1 | Response strobe |
| rsp_nack_i | input | 1 | Transaction was not acknowledged |
| rsp_count_i | input | 2 | Bytes transferred |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished cleanly (pulse) |
| err_o | output | 1 | Run failed (pulse) |
| variant_b_o | output | 1 | The 0x5E device is selected |

## Verification
A wrong step index or a wrong band choice shows up at the very next write handshake, as a wrong index or data byte on the command stream. A wrong variant choice shows up at the first write, as the wrong bus address. A broken pause counter shows up as a gap that is too short before the 00=02 or 00=03 write. A sequencer that ignores a nack shows up as a command issued after the failed write, within a few cycles of the response. A lost end-of-script marker shows up as a missing `done_o` or an extra command.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {K_WR, K_WAIT, K_END} kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [7:0] idx;
    logic [7:0] dat;
  } step_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PROBE, S_PROBE_RSP, S_STEP, S_WR_RSP, S_DELAY
  } state_e;

  localparam logic [6:0] ADDR_VAR_A = 7'h2C;
  localparam logic [6:0] ADDR_VAR_B = 7'h5E;
endpackage

// File: rtl/rcs_script_rom.sv
module rcs_script_rom
  import rcs_pkg::*;
#(
  parameter int STEP_W = 5
) (
  input  logic              var_b,
  input  logic [1:0]        mode,
  input  logic [STEP_W-1:0] step,
  output step_t             ent
);
  logic [7:0] fb_lo, fb_hi, prediv, txr, rxr, eqf, b_0b, b_0c, b_0a;

  function automatic step_t wr(input logic [7:0] i, input logic [7:0] d);
    return '{K_WR, i, d};
  endfunction

  always_comb begin
    fb_lo  = (mode == 2'd1) ? 8'h40 : 8'h80;
    fb_hi  = (mode == 2'd1) ? 8'h01 : 8'h02;
    prediv = (mode == 2'd0) ? 8'h02 : 8'h04;
    case (mode)
      2'd0:    begin txr = 8'hC0; rxr = 8'hC0; eqf = 8'h38; b_0b = 8'h80; end
      2'd1:    begin txr = 8'h70; rxr = 8'h40; eqf = 8'h28; b_0b = 8'h88; end
      default: begin txr = 8'h30; rxr = 8'h00; eqf = 8'h18; b_0b = 8'h9A; end
    endcase
    b_0c = (mode == 2'd2) ? 8'h49 : 8'h48;
    b_0a = (mode == 2'd2) ? 8'h36 : 8'h35;

    ent = '{K_END, 8'h00, 8'h00};
    if (!var_b) begin
      case (int'(step))
        0:  ent = wr(8'hFF, 8'h01);
        1:  ent = wr(8'h04, fb_lo);
        2:  ent = wr(8'h05, fb_hi);
        3:  ent = wr(8'h08, prediv);
        4:  ent = wr(8'h0E, 8'h10);
        5:  ent = wr(8'h01, 8'h81);
        6:  ent = '{K_WAIT, 8'h00, 8'h00};
        7:  ent = wr(8'h00, 8'h02);
        8:  ent = '{K_WAIT, 8'h00, 8'h00};
        9:  ent = wr(8'h00, 8'h03);
        10: ent = wr(8'h10, 8'h0F);
        11: ent = wr(8'h14, 8'h10);
        12: ent = wr(8'h16, 8'h10);
        13: ent = wr(8'h17, 8'h00);
        14: ent = wr(8'h12, 8'h28);
        15: ent = wr(8'h13, 8'h0F);
        16: ent = wr(8'h13, 8'h00);
        17: ent = wr(8'h11, txr);
        18: ent = wr(8'h30, 8'h0F);
        19: ent = wr(8'h32, 8'h00);
        20: ent = wr(8'h31, rxr);
        21: ent = wr(8'h34, 8'h00);
        22: ent = wr(8'h3C, 8'h04);
        23: ent = wr(8'h3D, 8'h06);
        24: ent = wr(8'h4D, eqf);
        25: ent = wr(8'h4C, 8'h03);
        26: ent = wr(8'hFF, 8'h00);
        27: ent = wr(8'h09, 8'h01);
        28: ent = wr(8'hE0, 8'h01);
        29: ent = wr(8'h09, 8'h00);
        default: ent = '{K_END, 8'h00, 8'h00};
      endcase
    end else begin
      case (int'(step))
        0: ent = wr(8'h09, 8'h06);
        1: ent = wr(8'h0B, b_0b);
        2: ent = wr(8'h0C, b_0c);
        3: ent = wr(8'h0D, 8'h00);
        4: ent = wr(8'h0A, b_0a);
        default: ent = '{K_END, 8'h00, 8'h00};
      endcase
    end
  end
endmodule

// File: rtl/rcs_ms_timer.sv
module rcs_ms_timer #(
  parameter int CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (start)          cnt <= CW'(CYCLES);
    else if (cnt != '0)      cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == CW'(1));
endmodule

// File: rtl/retimer_cfg_seq.sv
module retimer_cfg_seq
  import rcs_pkg::*;
#(
  parameter int RATE_W   = 16,
  parameter int CLK_HZ   = 250000000,
  parameter int WAIT_US  = 10000,
  parameter int SIM_WAIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_mbps_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [6:0]        cmd_addr_o,
  output logic              cmd_rd_o,
  output logic [1:0]        cmd_len_o,
  output logic [7:0]        cmd_byte0_o,
  output logic [7:0]        cmd_byte1_o,
  output logic              cmd_stop_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_nack_i,
  input  logic [1:0]        rsp_count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              variant_b_o
);
  localparam int STEP_W   = 5;
  localparam int WAIT_CYC = (SIM_WAIT != 0) ? SIM_WAIT : (CLK_HZ / 1000000) * WAIT_US;

  state_e              state;
  logic                boot_q, var_q, done_q, err_q;
  logic [RATE_W-1:0]   rate_q;
  logic [1:0]          mode_q, mode_sel;
  logic [STEP_W-1:0]   step_q;
  step_t               ent;
  logic                go, t_start, t_exp, rsp_ok_probe, rsp_ok_wr;

  rcs_script_rom #(.STEP_W(STEP_W)) i_rom (
    .var_b(var_q), .mode(mode_q), .step(step_q), .ent(ent)
  );

  rcs_ms_timer #(.CYCLES(WAIT_CYC)) i_tmr (
    .clk(clk), .rst_n(rst_n), .start(t_start), .expired(t_exp)
  );

  always_comb begin
    if (rate_q > RATE_W'(3400))                                  mode_sel = 2'd2;
    else if (rate_q > (var_q ? RATE_W'(2000) : RATE_W'(1200)))  mode_sel = 2'd1;
    else                                                         mode_sel = 2'd0;
  end

  assign go           = (state == S_IDLE) && (start_i || boot_q);
  assign t_start      = (state == S_STEP) && (ent.kind == K_WAIT);
  assign rsp_ok_probe = !rsp_nack_i && (rsp_count_i == 2'd1);
  assign rsp_ok_wr    = !rsp_nack_i && (rsp_count_i == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      boot_q <= 1'b1;
      var_q  <= 1'b0;
      rate_q <= '0;
      mode_q <= 2'd0;
      step_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        S_IDLE: if (go) begin
          rate_q <= rate_mbps_i;
          boot_q <= 1'b0;
          var_q  <= 1'b0;
          state  <= S_PROBE;
        end
        S_PROBE: if (cmd_ready_i) state <= S_PROBE_RSP;
        S_PROBE_RSP: if (rsp_valid_i) begin
          if (rsp_ok_probe) begin
            mode_q <= mode_sel;
            step_q <= '0;
            state  <= S_STEP;
          end else if (!var_q) begin
            var_q <= 1'b1;
            state <= S_PROBE;
          end else begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_STEP: begin
          case (ent.kind)
            K_END: begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end
            K_WAIT: begin
              step_q <= step_q + STEP_W'(1);
              state  <= S_DELAY;
            end
            default: if (cmd_ready_i) state <= S_WR_RSP;
          endcase
        end
        S_WR_RSP: if (rsp_valid_i) begin
          if (rsp_ok_wr) begin
            step_q <= step_q + STEP_W'(1);
            state  <= S_STEP;
          end else begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_DELAY: if (t_exp) state <= S_STEP;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (state == S_PROBE) || ((state == S_STEP) && (ent.kind == K_WR));
  assign cmd_addr_o  = var_q ? ADDR_VAR_B : ADDR_VAR_A;
  assign cmd_rd_o    = (state == S_PROBE);
  assign cmd_len_o   = (state == S_PROBE) ? 2'd1 : 2'd2;
  assign cmd_byte0_o = (state == S_PROBE) ? 8'h00 : ent.idx;
  assign cmd_byte1_o = (state == S_PROBE) ? 8'h00 : ent.dat;
  assign cmd_stop_o  = 1'b1;
  assign busy_o      = (state != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign variant_b_o = var_q;
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic [6:0] cmd_addr_o,
  input logic       cmd_rd_o,
  input logic [1:0] cmd_len_o,
  input logic [7:0] cmd_byte0_o,
  input logic [7:0] cmd_byte1_o,
  input logic       cmd_stop_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_rd_o)
      && $stable(cmd_byte0_o) && $stable(cmd_byte1_o));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  p_err_pulse_r10:  assert property (@(posedge clk) disable iff (!rst_n) err_o |=> !err_o);
  p_excl_r10:       assert property (@(posedge clk) disable iff (!rst_n) !(done_o && err_o));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !cmd_valid_o);

  p_write_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_rd_o |-> cmd_len_o == 2'd2 && cmd_stop_o);

  p_probe_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_rd_o |-> cmd_len_o == 2'd1 && (cmd_addr_o == 7'h2C || cmd_addr_o == 7'h5E));
endmodule

bind retimer_cfg_seq rcs_checker i_rcs_checker (.*);

// File: tb/test_retimer_cfg_seq.sv
module test_retimer_cfg_seq;
  localparam int WAITC = 20;

  typedef struct packed {
    logic       w;
    logic       rd;
    logic [6:0] a;
    logic [1:0] len;
    logic [7:0] b0;
    logic [7:0] b1;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] rate = 16'd4752;
  logic cmd_valid, cmd_ready = 1'b0, cmd_rd, cmd_stop;
  logic [6:0] cmd_addr;
  logic [1:0] cmd_len, rsp_count = 2'd0;
  logic [7:0] cmd_b0, cmd_b1;
  logic rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic busy, done, err, var_b;

  always #2 clk = ~clk;

  retimer_cfg_seq #(.SIM_WAIT(WAITC)) i_retimer_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rate_mbps_i(rate),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_addr_o(cmd_addr),
    .cmd_rd_o(cmd_rd), .cmd_len_o(cmd_len), .cmd_byte0_o(cmd_b0), .cmd_byte1_o(cmd_b1),
    .cmd_stop_o(cmd_stop), .rsp_valid_i(rsp_valid), .rsp_nack_i(rsp_nack),
    .rsp_count_i(rsp_count), .busy_o(busy), .done_o(done), .err_o(err),
    .variant_b_o(var_b)
  );

  int n_chk = 0, n_fail = 0;
  exp_t q[$];
  int cyc = 0, last_hs = 0, pend = 0, wr_seen = 0, nack_at = -1, wr_pushed = 0;
  bit ra = 1, rb = 0, got_done = 0, got_err = 0, skip = 0;
  int a_cnt = 1;
  logic pn;
  logic [1:0] pc;
  logic [6:0] cur_addr;
  exp_t got, e;

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, expv);
    end
  endtask

  // Scoreboard driver side
  task automatic push_probe(input logic [6:0] a);
    q.push_back('{1'b0, 1'b1, a, 2'd1, 8'h00, 8'h00});
  endtask

  task automatic pw(input logic w, input logic [7:0] i, input logic [7:0] d);
    if (!skip) begin
      q.push_back('{w, 1'b0, cur_addr, 2'd2, i, d});
      if (wr_pushed == nack_at) skip = 1;
      wr_pushed++;
    end
  endtask

  task automatic push_a(input int m);
    logic [7:0] tx, rx, eq;
    tx = (m == 0) ? 8'hC0 : (m == 1) ? 8'h70 : 8'h30;
    rx = (m == 0) ? 8'hC0 : (m == 1) ? 8'h40 : 8'h00;
    eq = (m == 0) ? 8'h38 : (m == 1) ? 8'h28 : 8'h18;
    cur_addr = 7'h2C;
    pw(0, 8'hFF, 8'h01); pw(0, 8'h04, m == 1 ? 8'h40 : 8'h80);
    pw(0, 8'h05, m == 1 ? 8'h01 : 8'h02); pw(0, 8'h08, m == 0 ? 8'h02 : 8'h04);
    pw(0, 8'h0E, 8'h10); pw(0, 8'h01, 8'h81);
    pw(1, 8'h00, 8'h02); pw(1, 8'h00, 8'h03);
    pw(0, 8'h10, 8'h0F); pw(0, 8'h14, 8'h10); pw(0, 8'h16, 8'h10); pw(0, 8'h17, 8'h00);
    pw(0, 8'h12, 8'h28); pw(0, 8'h13, 8'h0F); pw(0, 8'h13, 8'h00); pw(0, 8'h11, tx);
    pw(0, 8'h30, 8'h0F); pw(0, 8'h32, 8'h00); pw(0, 8'h31, rx); pw(0, 8'h34, 8'h00);
    pw(0, 8'h3C, 8'h04); pw(0, 8'h3D, 8'h06); pw(0, 8'h4D, eq); pw(0, 8'h4C, 8'h03);
    pw(0, 8'hFF, 8'h00); pw(0, 8'h09, 8'h01); pw(0, 8'hE0, 8'h01); pw(0, 8'h09, 8'h00);
  endtask

  task automatic push_b(input int m);
    cur_addr = 7'h5E;
    pw(0, 8'h09, 8'h06);
    pw(0, 8'h0B, (m == 2) ? 8'h9A : (m == 1) ? 8'h88 : 8'h80);
    pw(0, 8'h0C, (m == 2) ? 8'h49 : 8'h48);
    pw(0, 8'h0D, 8'h00);
    pw(0, 8'h0A, (m == 2) ? 8'h36 : 8'h35);
  endtask

  // Builds the expected command list; returns expected err and variant
  task automatic build(input int r, output bit x_err, output bit x_var);
    bit a_ok;
    skip = 0; wr_pushed = 0;
    a_ok = ra && (a_cnt == 1);
    push_probe(7'h2C);
    x_var = !a_ok;
    if (a_ok) push_a(r > 3400 ? 2 : r > 1200 ? 1 : 0);
    else begin
      push_probe(7'h5E);
      if (rb) push_b(r > 3400 ? 2 : r > 2000 ? 1 : 0);
    end
    x_err = (!a_ok && !rb) || skip;
  endtask

  task automatic finish_run(input string tag, input bit x_err, input bit x_var);
    while (!(got_done || got_err)) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(got_err == x_err, {tag, " R9 err outcome"}, got_err, x_err);
    chk(got_done == !x_err, {tag, " R10 done outcome"}, got_done, !x_err);
    chk(q.size() == 0, {tag, " R3 commands missing"}, q.size(), 0);
    chk(var_b == x_var, {tag, " R2 variant"}, var_b, x_var);
    chk(busy == 1'b0 && cmd_valid == 1'b0, {tag, " R10 idle after end"}, {busy, cmd_valid}, 0);
  endtask

  task automatic run(input string tag, input int r, input bit pa, input bit pb,
                     input int acnt, input int nk, input bit wiggle);
    bit x_err, x_var;
    ra = pa; rb = pb; a_cnt = acnt; nack_at = nk; wr_seen = 0;
    got_done = 0; got_err = 0;
    build(r, x_err, x_var);
    @(negedge clk);
    rate = 16'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (wiggle) begin
      repeat (3) @(negedge clk);
      rate = (r > 3400) ? 16'd500 : 16'd5000;  // R8: must not affect this run
    end
    finish_run(tag, x_err, x_var);
  endtask

  // Monitor and bus responder
  always @(negedge clk) begin
    cyc++;
    rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_count = 2'd0;
    if (pend != 0) begin
      pend--;
      if (pend == 0) begin
        rsp_valid = 1'b1; rsp_nack = pn; rsp_count = pc;
      end
    end
    cmd_ready = (cyc % 3) != 0;
    if (rst_n && cmd_valid && cmd_ready) begin
      got = '{1'b0, cmd_rd, cmd_addr, cmd_len, cmd_b0, cmd_b1};
      if (q.size() == 0) chk(0, "R9 unexpected command", int'(got), 0);
      else begin
        e = q.pop_front();
        chk(got[25:0] == e[25:0], "R5 command content", int'(got[25:0]), int'(e[25:0]));
        if (e.w) chk(cyc - last_hs >= WAITC, "R6 power-up gap", cyc - last_hs, WAITC);
      end
      last_hs = cyc;
      if (cmd_rd) begin
        if (cmd_addr == 7'h2C) begin pn = !ra; pc = ra ? 2'(a_cnt) : 2'd0; end
        else begin pn = !rb; pc = rb ? 2'd1 : 2'd0; end
      end else begin
        pn = (wr_seen == nack_at);
        pc = pn ? 2'd0 : 2'd2;
        wr_seen++;
      end
      pend = 2;
    end
    if (done) got_done = 1;
    if (err)  got_err = 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog act=%0d exp=0", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit x_err, x_var;
    ra = 1; rb = 0; a_cnt = 1; nack_at = -1;
    build(4752, x_err, x_var);
    repeat (5) @(negedge clk);
    chk({cmd_valid, busy, done, err} == 4'b0, "R1 reset outputs", {cmd_valid, busy, done, err}, 0);
    rst_n = 1'b1;
    finish_run("boot", x_err, x_var);              // R1, R4, R5, R6 in band 2

    run("a3400", 3400, 1, 0, 1, -1, 0);            // R4 band 1 boundary
    run("a1200", 1200, 1, 0, 1, -1, 0);            // R4 band 0 boundary
    run("a1201", 1201, 1, 1, 1, -1, 0);            // R4 band 1
    run("a3401", 3401, 1, 0, 1, -1, 1);            // R4 band 2, R8 rate change
    run("b4752", 4752, 0, 1, 1, -1, 0);            // R7 band 2
    run("b2000", 2000, 0, 1, 1, -1, 1);            // R7 band 0 boundary, R8
    run("b2001", 2001, 0, 1, 1, -1, 0);            // R7 band 1
    run("b3400", 3400, 0, 1, 1, -1, 0);            // R7 band 1 boundary
    run("none",  4752, 0, 0, 1, -1, 0);            // R2 neither found
    run("acnt2", 2500, 1, 1, 2, -1, 0);            // R2 wrong byte count
    run("anack", 4752, 1, 0, 1, 5, 0);             // R9 nack on charge-pump write
    run("bnack", 1500, 0, 1, 1, 0, 0);             // R9 nack on first write
    run("again", 800,  1, 0, 1, -1, 0);            // R10 clean run after an error

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule